// File: doc/BRIEF.md
# Status Flag Register with Branch Condition Evaluator

This block keeps the processor's 8-bit status word and decides whether a conditional branch or a conditional skip goes ahead. It takes two kinds of writes.

- **ALU write-back.** A mask selects which flags the arithmetic unit replaces with new values.
- **Single-bit command.** A command sets or clears one flag, chosen by its index.

Every named flag operation reduces to the single-bit command at the index of that flag. So do the set-carry, clear-zero and set-interrupt-enable operations.

The condition evaluator has one generic test: "selected bit equals polarity". The selected bit is either a status bit or a bit of an I/O byte supplied on the ports. All the named branches map onto this one test. These include equal, not-equal, same-or-higher, lower, greater-or-equal, less-than, overflow-set and overflow-clear, as well as the I/O skip-if-set and skip-if-clear operations. The decode stage supplies the index and the polarity.

The taken output is combinational. It is based on the register value as it stands in the current cycle, before any write in that cycle takes effect. Target address calculation and interrupts belong to other blocks.

Top module: `sreg_branch_unit`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after reset is released, `status_q` is 8'h00.
- R2: When `alu_we` is 1, each bit of `status_q` whose `alu_mask` bit is 1 takes the matching `alu_flags` bit at the next clock edge. Bits whose mask bit is 0 keep their value.
- R3: The flags sit at fixed positions, from bit 7 down to bit 0: I, T, H, S, V, N, Z, C. So C is at index 0, Z at 1, N at 2, V at 3, S at 4, H at 5, T at 6 and I at 7.
- R4: When `bit_valid` is 1 and `bit_set` is 1, bit `bit_idx` becomes 1 at the next edge. When `bit_set` is 0 instead, that bit becomes 0. No other bit is touched by this command.
- R5: When an ALU write and a single-bit command hit the same bit in one cycle, the command's value wins. ALU writes to other masked bits still take effect in that cycle.
- R6: With `cond_mode` = 2'b01 (status test), `taken` = 1 exactly when `status_q[cond_idx]` equals `cond_pol`. For example, equal is index 1 with polarity 1, lower is index 0 with polarity 1, and less-than is index 4 with polarity 1.
- R7: With `cond_mode` = 2'b10 (I/O test), `taken` = 1 exactly when `io_byte[cond_idx]` equals `cond_pol`.
- R8: With `cond_mode` = 2'b00 (no condition) or 2'b11 (reserved), `taken` is 0.
- R9: `taken` reflects `status_q` before any write in the same cycle. The write shows up in `taken` only from the next cycle.
- R10: When neither `alu_we` nor `bit_valid` is 1, `status_q` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| alu_we | input | 1 | ALU flag write enable |
| alu_mask | input | 8 | Per-flag write mask for the ALU write |
| alu_flags | input | 8 | New flag values from the ALU |
| bit_valid | input | 1 | Single-bit command valid |
| bit_set | input | 1 | 1 sets the indexed bit, 0 clears it |
| bit_idx | input | 3 | Index of the bit the command targets |
| cond_mode | input | 2 | 00 none, 01 status test, 10 I/O test, 11 reserved |
| cond_idx | input | 3 | Bit tested by the condition |
| cond_pol | input | 1 | Bit value that makes the condition true |
| io_byte | input | 8 | I/O byte used by the I/O test |
| status_q | output | 8 | Status register contents |
| taken | output | 1 | Branch or skip taken |

## Verification
The write assertions compare `status_q` with the previous cycle's inputs. They therefore assume the inputs are stable and known at each rising edge, and that no input is X after reset. The bench keeps to this by driving every input on the falling edge. It also holds all enables low during reset and on the first cycle after reset is released.

The condition assertion assumes `cond_mode`, `cond_idx`, `cond_pol` and `io_byte` are settled at each edge. The bench changes them only on the falling edge and reads `taken` before the next rising edge.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int SR_W  = 8;
  localparam int SR_IW = $clog2(SR_W);

  typedef enum logic [1:0] {
    COND_OFF    = 2'd0,
    COND_STATUS = 2'd1,
    COND_IO     = 2'd2,
    COND_RSVD   = 2'd3
  } cond_mode_e;

  // Masked replacement: bits with mask set take val, others keep cur.
  function automatic logic [SR_W-1:0] merge_masked(
    input logic [SR_W-1:0] cur,
    input logic [SR_W-1:0] mask,
    input logic [SR_W-1:0] val
  );
    return (cur & ~mask) | (val & mask);
  endfunction

  // One-hot decode of a bit index.
  function automatic logic [SR_W-1:0] idx_onehot(input logic [SR_IW-1:0] idx);
    logic [SR_W-1:0] r;
    r = '0;
    r[idx] = 1'b1;
    return r;
  endfunction

  // Generic condition: the chosen bit equals the wanted polarity.
  function automatic logic bit_matches(
    input logic [SR_W-1:0]  word,
    input logic [SR_IW-1:0] idx,
    input logic             pol
  );
    return word[idx] == pol;
  endfunction
endpackage

// File: rtl/sreg_next.sv
module sreg_next
  import sreg_pkg::*;
(
  input  logic [SR_W-1:0]  cur,
  input  logic             alu_we,
  input  logic [SR_W-1:0]  alu_mask,
  input  logic [SR_W-1:0]  alu_flags,
  input  logic             bit_valid,
  input  logic             bit_set,
  input  logic [SR_IW-1:0] bit_idx,
  output logic [SR_W-1:0]  alu_view,
  output logic [SR_W-1:0]  cmd_hit,
  output logic [SR_W-1:0]  nxt
);
  logic [SR_W-1:0] eff_mask;

  assign eff_mask = alu_we ? alu_mask : '0;
  assign alu_view = merge_masked(cur, eff_mask, alu_flags);
  assign cmd_hit  = bit_valid ? idx_onehot(bit_idx) : '0;

  // Per-bit priority: explicit command over ALU value over held value.
  for (genvar b = 0; b < SR_W; b++) begin : g_bit
    always_comb begin
      if (cmd_hit[b]) nxt[b] = bit_set;
      else            nxt[b] = alu_view[b];
    end
  end
endmodule

// File: rtl/sreg_cond.sv
module sreg_cond
  import sreg_pkg::*;
(
  input  logic [SR_W-1:0]  status,
  input  logic [SR_W-1:0]  io_byte,
  input  logic [1:0]       mode,
  input  logic [SR_IW-1:0] idx,
  input  logic             pol,
  output logic             status_hit,
  output logic             io_hit,
  output logic             taken
);
  cond_mode_e mode_e;

  assign mode_e     = cond_mode_e'(mode);
  assign status_hit = bit_matches(status, idx, pol);
  assign io_hit     = bit_matches(io_byte, idx, pol);

  always_comb begin
    unique case (mode_e)
      COND_STATUS: taken = status_hit;
      COND_IO:     taken = io_hit;
      default:     taken = 1'b0;
    endcase
  end
endmodule

// File: rtl/sreg_branch_unit.sv
module sreg_branch_unit
  import sreg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alu_we,
  input  logic [SR_W-1:0]  alu_mask,
  input  logic [SR_W-1:0]  alu_flags,
  input  logic             bit_valid,
  input  logic             bit_set,
  input  logic [SR_IW-1:0] bit_idx,
  input  logic [1:0]       cond_mode,
  input  logic [SR_IW-1:0] cond_idx,
  input  logic             cond_pol,
  input  logic [SR_W-1:0]  io_byte,
  output logic [SR_W-1:0]  status_q,
  output logic             taken
);
  logic [SR_W-1:0] nxt;
  logic [SR_W-1:0] alu_view;
  logic [SR_W-1:0] cmd_hit;
  logic            status_hit;
  logic            io_hit;
  logic            any_write;

  assign any_write = alu_we | bit_valid;

  sreg_next u_next (
    .cur       (status_q),
    .alu_we    (alu_we),
    .alu_mask  (alu_mask),
    .alu_flags (alu_flags),
    .bit_valid (bit_valid),
    .bit_set   (bit_set),
    .bit_idx   (bit_idx),
    .alu_view  (alu_view),
    .cmd_hit   (cmd_hit),
    .nxt       (nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         status_q <= '0;
    else if (any_write) status_q <= nxt;
  end

  sreg_cond u_cond (
    .status     (status_q),
    .io_byte    (io_byte),
    .mode       (cond_mode),
    .idx        (cond_idx),
    .pol        (cond_pol),
    .status_hit (status_hit),
    .io_hit     (io_hit),
    .taken      (taken)
  );

  // R4
  bit_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && bit_set) |=> status_q[$past(bit_idx)]);

  // R4
  bit_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && !bit_set) |=> !status_q[$past(bit_idx)]);

  // R2
  alu_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_we && !bit_valid) |=>
      ((status_q & $past(alu_mask)) == ($past(alu_flags) & $past(alu_mask))) &&
      ((status_q & ~$past(alu_mask)) == ($past(status_q) & ~$past(alu_mask))));

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !any_write |=> $stable(status_q));

  // R8
  idle_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_mode == 2'b00 || cond_mode == 2'b11) |-> !taken);

  // R6
  status_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_mode == 2'b01) |-> (taken == (status_q[cond_idx] == cond_pol)));
endmodule

// File: tb/tb_sreg_branch_unit.sv
module tb_sreg_branch_unit;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       alu_we;
  logic [7:0] alu_mask, alu_flags;
  logic       bit_valid, bit_set;
  logic [2:0] bit_idx;
  logic [1:0] cond_mode;
  logic [2:0] cond_idx;
  logic       cond_pol;
  logic [7:0] io_byte;
  logic [7:0] status_q;
  logic       taken;

  int n_tests = 0;
  int n_fail  = 0;
  logic [7:0] model;

  always #5 clk = ~clk;

  sreg_branch_unit dut (
    .clk(clk), .rst_n(rst_n), .alu_we(alu_we), .alu_mask(alu_mask),
    .alu_flags(alu_flags), .bit_valid(bit_valid), .bit_set(bit_set),
    .bit_idx(bit_idx), .cond_mode(cond_mode), .cond_idx(cond_idx),
    .cond_pol(cond_pol), .io_byte(io_byte), .status_q(status_q), .taken(taken)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic idle_inputs();
    alu_we = 0; alu_mask = 0; alu_flags = 0;
    bit_valid = 0; bit_set = 0; bit_idx = 0;
  endtask

  // Wait for the next rising edge, then return on the falling edge.
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic bit_cmd(input logic s, input logic [2:0] i);
    bit_valid = 1; bit_set = s; bit_idx = i;
    tick();
    idle_inputs();
    model[i] = s;
  endtask

  task automatic alu_write(input logic [7:0] m, input logic [7:0] f);
    alu_we = 1; alu_mask = m; alu_flags = f;
    tick();
    idle_inputs();
    model = (model & ~m) | (f & m);
  endtask

  task automatic t_reset();
    rst_n = 0;
    idle_inputs();
    cond_mode = 0; cond_idx = 0; cond_pol = 0; io_byte = 0;
    repeat (3) @(negedge clk);
    check("R1 during reset", status_q, 8'h00);
    rst_n = 1;
    tick();
    model = 8'h00;
    check("R1 after reset", status_q, 8'h00);
    check("R8 no cond after reset", {7'b0, taken}, 8'h00);
  endtask

  task automatic t_alu();
    alu_write(8'hFF, 8'hA5);
    check("R2 full mask", status_q, 8'hA5);
    alu_write(8'h0F, 8'h3C);
    check("R2 low mask", status_q, model);
    alu_write(8'h00, 8'hFF);
    check("R2 empty mask", status_q, model);
    alu_write(8'hFF, 8'h00);
    check("R2 clear all", status_q, 8'h00);
  endtask

  task automatic t_named_flags();
    // Index order I,T,H,S,V,N,Z,C maps to 7 down to 0.
    bit_cmd(1'b1, 3'd0);
    check("R3 set carry", status_q, 8'h01);
    bit_cmd(1'b1, 3'd1);
    check("R3 set zero", status_q, 8'h03);
    bit_cmd(1'b1, 3'd7);
    check("R3 set interrupt enable", status_q, 8'h83);
    bit_cmd(1'b0, 3'd0);
    check("R4 clear carry", status_q, 8'h82);
    for (int i = 0; i < 8; i++) begin
      bit_cmd(1'b1, 3'(i));
      check("R4 set by index", status_q, model);
    end
    check("R4 all set", status_q, 8'hFF);
    for (int i = 7; i >= 0; i--) begin
      bit_cmd(1'b0, 3'(i));
      check("R4 clear by index", status_q, model);
    end
  endtask

  task automatic t_conflict();
    alu_write(8'hFF, 8'h00);
    alu_we = 1; alu_mask = 8'h0F; alu_flags = 8'h0F;
    bit_valid = 1; bit_set = 0; bit_idx = 3'd2;
    tick();
    idle_inputs();
    check("R5 clear beats alu", status_q, 8'h0B);
    alu_we = 1; alu_mask = 8'hF0; alu_flags = 8'h00;
    bit_valid = 1; bit_set = 1; bit_idx = 3'd6;
    tick();
    idle_inputs();
    check("R5 set beats alu", status_q, 8'h4B);
    model = 8'h4B;
  endtask

  task automatic t_branches();
    // Z set, C clear, S set, V clear.
    alu_write(8'hFF, 8'h12);
    cond_mode = 2'b01;
    cond_idx = 3'd1; cond_pol = 1; #1;
    check("R6 equal taken", {7'b0, taken}, 8'h01);
    cond_pol = 0; #1;
    check("R6 not-equal not taken", {7'b0, taken}, 8'h00);
    cond_idx = 3'd0; cond_pol = 0; #1;
    check("R6 same-or-higher taken", {7'b0, taken}, 8'h01);
    cond_pol = 1; #1;
    check("R6 lower not taken", {7'b0, taken}, 8'h00);
    cond_idx = 3'd4; cond_pol = 1; #1;
    check("R6 less-than taken", {7'b0, taken}, 8'h01);
    cond_idx = 3'd3; cond_pol = 1; #1;
    check("R6 overflow-set not taken", {7'b0, taken}, 8'h00);
    cond_pol = 0; #1;
    check("R6 overflow-clear taken", {7'b0, taken}, 8'h01);
    cond_mode = 2'b11; #1;
    check("R8 reserved mode", {7'b0, taken}, 8'h00);
    cond_mode = 2'b00; #1;
    check("R8 off mode", {7'b0, taken}, 8'h00);
  endtask

  task automatic t_io();
    cond_mode = 2'b10; io_byte = 8'h80;
    cond_idx = 3'd7; cond_pol = 1; #1;
    check("R7 io bit set skip", {7'b0, taken}, 8'h01);
    cond_pol = 0; #1;
    check("R7 io bit clear no skip", {7'b0, taken}, 8'h00);
    cond_idx = 3'd2; #1;
    check("R7 io low bit clear skip", {7'b0, taken}, 8'h01);
    io_byte = 8'h04; #1;
    check("R7 io changed", {7'b0, taken}, 8'h00);
    cond_mode = 2'b00;
  endtask

  task automatic t_pre_update();
    alu_write(8'hFF, 8'h00);
    cond_mode = 2'b01; cond_idx = 3'd1; cond_pol = 1;
    bit_valid = 1; bit_set = 1; bit_idx = 3'd1; #1;
    check("R9 before edge old value", {7'b0, taken}, 8'h00);
    @(posedge clk); #1;
    idle_inputs();
    model[1] = 1'b1;
    check("R9 after edge new value", {7'b0, taken}, 8'h01);
    @(negedge clk);
    cond_mode = 2'b00;
  endtask

  task automatic t_hold();
    alu_mask = 8'hFF; alu_flags = 8'hFF;
    bit_set = 0; bit_idx = 3'd1;
    repeat (3) tick();
    check("R10 hold no enables", status_q, model);
    idle_inputs();
  endtask

  initial begin
    t_reset();
    t_alu();
    t_named_flags();
    t_conflict();
    t_branches();
    t_io();
    t_pre_update();
    t_hold();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #100000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired got=hung exp=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule